// File: doc/BRIEF.md
# PCI Configuration Address Former

This block turns a configuration request, given as a bus number, a device/function number and a register offset, into the two values a host bridge needs to reach PCI configuration space through a memory window. The first value is the byte offset inside the configuration window. The second is the word to load into the register that maps that window onto the PCI bus. Requests on bus 0, the segment local to the host, become type 0 cycles. Requests on any other bus become type 1 cycles. Requests with an out-of-range field are flagged as errors.

A request is accepted on a clock edge when `req_valid` and `req_ready` are both high. The result appears on the registered outputs one cycle later, together with a one-cycle `rsp_valid` pulse, and stays unchanged until the next request is accepted. The block does not run the bus cycle and does not reprogram the window.

Top module: `cfg_addr_former`

## Requirements
- R1: For a legal request, the map word has bits 3:1 equal to 3'b101. Bit 0 of the map word is 0 when the bus number is 0 (type 0) and 1 when the bus number is nonzero (type 1). The base map word is therefore 0x0A for type 0 and 0x0B for type 1.
- R2: For type 0, the function number (devfn bits 2:0) appears in address bits 10:8.
- R3: For type 0 with slot (devfn bits 7:3) of 12 or less, exactly one device-select bit is set in address bits 31:11, at position slot+11. The map word is exactly 0x0A.
- R4: For type 0 with slot above 12, address bits 31:11 are all zero. The map word is 0x0A with bit slot-4 also set, so bits 31:9 hold exactly one set bit.
- R5: For type 1, the address is the bus number in bits 23:16 and the full devfn in bits 15:8, plus the offset. Bits 31:24 are zero.
- R6: The register offset is added to the formed address. Since the formed address has bits 7:0 clear, address bits 7:0 equal the offset.
- R7: A request with bus number, devfn or offset above 255 returns `rsp_err`=1 with the address and map word both zero.
- R8: Outputs are registered. `rsp_valid` is high exactly in the cycle after an accepted request, and address, map and error outputs hold their values until the next accepted request.
- R9: `req_ready` is low while reset is asserted and goes high on the first clock edge after reset is released. While high, it accepts at most one request per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bus | input | IN_W | Bus number |
| req_devfn | input | IN_W | Device/function number (slot in 7:3, function in 2:0) |
| req_offset | input | IN_W | Configuration register byte offset |
| rsp_valid | output | 1 | One-cycle pulse when a new result is on the outputs |
| rsp_err | output | 1 | Request was illegal |
| rsp_addr | output | 32 | Offset within the configuration window |
| rsp_map | output | 32 | Value for the window's map register |

## Verification
The hardest cases to reach are the split of the type 0 device select between the address and the map word, at the boundary slots 12 and 13, and illegal requests where only one field is out of range. Uniform random values would seldom produce a zero bus or a field just above 255. For this reason the stimulus draws bus 0 about half the time, sweeps every slot on bus 0 directly, and places single-field overflows right at the 255/256 edge. An idle cycle after each response checks that the outputs hold their values.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
  localparam int CFG_W      = 32;
  localparam int FIELD_MAX  = 255;
  localparam int SLOT_SPLIT = 12;
  localparam int SEL_BASE   = 11;
  localparam int MAP_SHIFT  = 4;
  localparam logic [CFG_W-1:0] MAP_T0 = 32'h0000_000A;
  localparam logic [CFG_W-1:0] MAP_T1 = 32'h0000_000B;

  typedef enum logic {CYC_T0 = 1'b0, CYC_T1 = 1'b1} cyc_kind_t;

  typedef struct packed {
    logic [CFG_W-1:0] addr;
    logic [CFG_W-1:0] map;
  } cfg_word_t;
endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
  import cfgaddr_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] bus,
  input  logic [IN_W-1:0] devfn,
  input  logic [IN_W-1:0] offset,
  output logic            legal,
  output cyc_kind_t       kind
);
  localparam logic [IN_W-1:0] LIMIT = IN_W'(FIELD_MAX);

  always_comb begin
    legal = (bus <= LIMIT) && (devfn <= LIMIT) && (offset <= LIMIT);
    kind  = (bus == '0) ? CYC_T0 : CYC_T1;
  end
endmodule

// File: rtl/cfg_type0_former.sv
module cfg_type0_former
  import cfgaddr_pkg::*;
(
  input  logic [7:0] devfn,
  output cfg_word_t  word
);
  logic [4:0]  slot;
  logic [2:0]  func;
  logic [31:0] slot_dec;
  logic [31:0] addr_sel;
  logic [31:0] map_sel;

  always_comb begin
    slot     = devfn[7:3];
    func     = devfn[2:0];
    slot_dec = 32'd1 << slot;
    // low slots select directly in the address, high slots via the map word
    addr_sel = {8'd0, slot_dec[SLOT_SPLIT:0], 11'd0};
    map_sel  = {4'd0, slot_dec[31:SLOT_SPLIT+1], 9'd0};
    word.addr = addr_sel | {21'd0, func, 8'd0};
    word.map  = MAP_T0 | map_sel;
  end
endmodule

// File: rtl/cfg_type1_former.sv
module cfg_type1_former
  import cfgaddr_pkg::*;
(
  input  logic [7:0] bus,
  input  logic [7:0] devfn,
  output cfg_word_t  word
);
  always_comb begin
    word.addr = {8'd0, bus, devfn, 8'd0};
    word.map  = MAP_T1;
  end
endmodule

// File: rtl/cfg_addr_former.sv
module cfg_addr_former
  import cfgaddr_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IN_W-1:0]  req_bus,
  input  logic [IN_W-1:0]  req_devfn,
  input  logic [IN_W-1:0]  req_offset,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [CFG_W-1:0] rsp_addr,
  output logic [CFG_W-1:0] rsp_map
);
  logic      legal;
  cyc_kind_t kind;
  cfg_word_t w_t0, w_t1, w_sel, w_d, w_q;
  logic      accept;
  logic      err_d, err_q, vld_d, vld_q, rdy_q;

  cfg_req_check #(.IN_W(IN_W)) u_check (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
    .legal(legal), .kind(kind)
  );

  cfg_type0_former u_t0 (.devfn(req_devfn[7:0]), .word(w_t0));
  cfg_type1_former u_t1 (.bus(req_bus[7:0]), .devfn(req_devfn[7:0]), .word(w_t1));

  always_comb begin
    accept = req_valid && rdy_q;
    w_sel  = (kind == CYC_T0) ? w_t0 : w_t1;
    w_sel.addr = w_sel.addr + {{(CFG_W-8){1'b0}}, req_offset[7:0]};
    vld_d  = accept;
    if (accept) begin
      err_d = !legal;
      w_d   = legal ? w_sel : '0;
    end else begin
      err_d = err_q;
      w_d   = w_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
      w_q   <= '0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= vld_d;
      err_q <= err_d;
      w_q   <= w_d;
    end
  end

  assign req_ready = rdy_q;
  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_addr  = w_q.addr;
  assign rsp_map   = w_q.map;

  // R1
  map_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_map[3:1] == 3'b101));
  // R3
  low_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && rsp_map == MAP_T0) |-> ($countones(rsp_addr[31:11]) == 1));
  // R4
  high_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && !rsp_map[0] && rsp_map[31:4] != '0)
      |-> (rsp_addr[31:11] == '0 && $countones(rsp_map[31:9]) == 1));
  // R6
  offset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_addr[7:0] == $past(req_offset[7:0])));
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_addr == '0 && rsp_map == '0));
  // R8
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_map) && $stable(rsp_err)));
endmodule

// File: tb/test_cfg_addr_former.sv
module test_cfg_addr_former;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_bus, req_devfn, req_offset;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_addr, rsp_map;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        e_err;
  logic [31:0] e_addr, e_map;

  always #5 clk = ~clk;

  cfg_addr_former i_cfg_addr_former (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_map(rsp_map)
  );

  function automatic void model(input int b, input int d, input int o);
    int slot;
    if (b > 255 || d > 255 || o > 255) begin
      e_err = 1'b1; e_addr = 0; e_map = 0;
    end else if (b == 0) begin
      slot = d / 8;
      e_err = 1'b0; e_addr = (d % 8) << 8; e_map = 32'h0A;
      if (slot > 12) e_map = e_map | (32'd1 << (slot - 4));
      else           e_addr = e_addr | (32'd1 << (slot + 11));
      e_addr = e_addr + o;
    end else begin
      e_err = 1'b0; e_map = 32'h0B;
      e_addr = (b << 16) + (d << 8) + o;
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input int b, input int d, input int o);
    if (b > 255 || d > 255 || o > 255) return "R7";
    if (b != 0) return "R5";
    if (d / 8 > 12) return "R4";
    return "R3";
  endfunction

  task automatic apply(input int b, input int d, input int o);
    string t;
    @(negedge clk);
    req_valid = 1'b1; req_bus = 16'(b); req_devfn = 16'(d); req_offset = 16'(o);
    @(negedge clk);
    req_valid = 1'b0;
    model(b, d, o);
    t = tag(b, d, o);
    check("R8 valid", 32'(rsp_valid), 32'd1);
    check({t, " err"}, 32'(rsp_err), 32'(e_err));
    check({t, " addr"}, rsp_addr, e_addr);
    check({t, " map"}, rsp_map, e_map);
    @(negedge clk);
    check("R8 idle valid", 32'(rsp_valid), 32'd0);
    check("R8 hold addr", rsp_addr, e_addr);
    check("R8 hold map", rsp_map, e_map);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_bus = 0; req_devfn = 0; req_offset = 0;
    repeat (3) @(negedge clk);
    check("R9 ready in reset", 32'(req_ready), 32'd0);
    check("R8 valid in reset", 32'(rsp_valid), 32'd0);
    check("R8 addr in reset", rsp_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", 32'(req_ready), 32'd1);

    // R1 type codes
    apply(0, 8'h08, 0);
    check("R1 t0 bit0", 32'(rsp_map[0]), 32'd0);
    apply(3, 8'h08, 0);
    check("R1 t1 bit0", 32'(rsp_map[0]), 32'd1);
    // R2 function bits
    apply(0, 8'h2D, 0);
    check("R2 func", 32'(rsp_addr[10:8]), 32'd5);
    // R3 / R4 every slot on bus 0, boundary 12/13 included
    for (int s = 0; s < 32; s++) apply(0, s * 8 + (s % 8), (s * 7) % 256);
    // R5 type 1 edges
    apply(255, 255, 255);
    apply(1, 0, 0);
    // R6 offset addition
    apply(0, 8'h61, 8'hFC);
    check("R6 offset low", 32'(rsp_addr[7:0]), 32'hFC);
    // R7 single-field overflow at the edge
    apply(256, 8, 4);
    apply(0, 256, 4);
    apply(2, 8, 256);
    apply(16'hFFFF, 16'hFFFF, 16'hFFFF);
    apply(0, 0, 8);
    // random
    for (int i = 0; i < 400; i++) begin
      int b, d, o, r;
      r = $urandom_range(0, 9);
      b = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 255);
      d = $urandom_range(0, 255);
      o = $urandom_range(0, 255);
      if (r == 0) b = $urandom_range(256, 65535);
      if (r == 1) d = $urandom_range(256, 65535);
      if (r == 2) o = $urandom_range(256, 65535);
      apply(b, d, o);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule